// File: doc/BRIEF.md
# Serial-Port Interrupt Identification Logic

This block decides which interrupt a single serial port presents to its host, and how. Seven condition inputs come from the port's datapath. Each one is latched into a pending flag when its interrupt-enable bit is set: receive line error, receive data ready or trigger reached, receive timeout, transmit holding empty, modem status change, flow-off or special character seen, and a rising edge on either flow-control pin. The flags are ranked by a fixed priority. The highest-ranked flag that is enabled and pending is shown as an encoded status byte. The same state drives an interrupt request output.

A host read of the status byte is signalled by a one-cycle strobe. The strobe clears only the source the byte reported in that cycle, so the next lower pending source then becomes visible. The upper half of the enable register can be written only while the enhanced-feature bit is set. When FIFO mode is on, the status byte carries two mode flag bits and a distinct timeout code.

The status byte is a combinational function of registered state and the FIFO-mode input. A read strobe, an enable write or a new condition takes effect at the next rising clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset all enable bits are 0, no source is pending, `isr_data` reads 8'h01 and `irq` is 0.
- R2: Priority runs from highest to lowest, and `isr_data[5:0]` shows the code of the winner: line error 6'b000110, receive ready 6'b000100, receive timeout 6'b001100 (FIFO mode), transmit empty 6'b000010, modem change 6'b000000, flow-off/special 6'b010000, flow-pin edge 6'b100000. With nothing pending the field reads 6'b000001.
- R3: `isr_data[0]` is 0 exactly when some enabled source is pending.
- R4: An `isr_rd` strobe clears only the source shown in that cycle. Other pending sources remain and the next one shows after the edge.
- R5: The receive-timeout code sets bit 3 only while `fifo_en` is 1. With `fifo_en` 0 it reads 6'b000100 and bit 3 is always 0.
- R6: `isr_data[7:6]` reads 2'b11 while `fifo_en` is 1 and 2'b00 otherwise.
- R7: An `ier_wr` always writes enable bits 3:0. It writes bits 7:4 only when `enh_en` is 1; otherwise those bits keep their value.
- R8: A 0-to-1 transition of `rts_pin` while enable bit 6 is set, or of `cts_pin` while enable bit 7 is set, makes the flow-pin edge source pending. Levels and falling edges do not.
- R9: Enable bit map: bit 0 covers receive ready and receive timeout, bit 1 transmit empty, bit 2 line error, bit 3 modem change, bit 5 flow-off/special, and bits 6 and 7 the flow pins. Bit 4 is stored but drives no source. A condition that is high in a cycle whose enable is set stays pending after the condition drops.
- R10: Clearing an enable bit hides its pending source from `isr_data` and `irq` without dropping it. Setting the bit again shows the source once more.
- R11: `irq` is 1 exactly when at least one enabled source is pending.
- R12: If a source's condition is still present in the cycle its read strobe clears it, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| enh_en | input | 1 | Enhanced-feature bit; opens enable bits 7:4 to writes |
| fifo_en | input | 1 | FIFO mode selected |
| line_err | input | 1 | Receive line error condition |
| rx_ready | input | 1 | Receive data ready or trigger level reached |
| rx_timeout | input | 1 | Receive character timeout |
| tx_empty | input | 1 | Transmit holding register empty |
| modem_chg | input | 1 | Modem status changed |
| xoff_det | input | 1 | Flow-off or special character detected |
| cts_pin | input | 1 | Clear-to-send pin level |
| rts_pin | input | 1 | Request-to-send pin level |
| isr_rd | input | 1 | Host read strobe for the status byte |
| isr_data | output | 8 | Encoded interrupt status byte |
| irq | output | 1 | Interrupt request |

## Verification
A read strobe can clear a source in the same cycle that the source's condition sets it again. It can also clear one source while a lower-priority source is being latched. The bench provokes both. It holds `rx_ready` high across a read, and it raises several conditions in the same cycle and then reads them out one by one. A behavioural reference model, written with integer arrays, takes the read before it applies the new sets in each cycle. The status byte and `irq` are compared against that model after every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 7;
    localparam int DATA_W  = 8;

    // ranking: lower value wins
    typedef enum logic [2:0] {
        SRC_LINE  = 3'd0,
        SRC_RXRDY = 3'd1,
        SRC_RXTO  = 3'd2,
        SRC_TXE   = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_XOFF  = 3'd5,
        SRC_FLOW  = 3'd6,
        SRC_NONE  = 3'd7
    } src_e;

    // enable-register bit positions
    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;
    localparam int EN_XOFF = 5;
    localparam int EN_RTS  = 6;
    localparam int EN_CTS  = 7;

    localparam int LOCK_LSB = 4;

endpackage

// File: rtl/uart_irq_enables.sv
module uart_irq_enables #(
    parameter int W        = 8,
    parameter int LOCK_LSB = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         unlock,
    output logic [W-1:0] ier
);

    localparam logic [W-1:0] LOW_MASK = {{(W-LOCK_LSB){1'b0}}, {LOCK_LSB{1'b1}}};

    logic [W-1:0] open_mask;

    always_comb begin
        open_mask = unlock ? {W{1'b1}} : LOW_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier <= '0;
        end else if (wr) begin
            ier <= (wdata & open_mask) | (ier & ~open_mask);
        end
    end

endmodule

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pin;
        end
    end

    always_comb begin
        rise = pin & ~prev_q;
    end

endmodule

// File: rtl/uart_irq_latch.sv
module uart_irq_latch #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                pend_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                pend_o[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output src_e         sel,
    output logic         valid
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    always_comb begin
        grant = req & ~(req - ONE);
        valid = |req;
        sel   = SRC_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                sel = src_e'(i);
            end
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ier_wr,
    input  logic [7:0] ier_wdata,
    input  logic       enh_en,
    input  logic       fifo_en,
    input  logic       line_err,
    input  logic       rx_ready,
    input  logic       rx_timeout,
    input  logic       tx_empty,
    input  logic       modem_chg,
    input  logic       xoff_det,
    input  logic       cts_pin,
    input  logic       rts_pin,
    input  logic       isr_rd,
    output logic [7:0] isr_data,
    output logic       irq
);

    logic [DATA_W-1:0]  ier_q;
    logic [1:0]         pin_rise;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] src_set;
    logic [NUM_SRC-1:0] src_clr;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    src_e               win;
    logic               any;
    logic [5:0]         code;

    uart_irq_enables #(.W(DATA_W), .LOCK_LSB(LOCK_LSB)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ier_wr),
        .wdata  (ier_wdata),
        .unlock (enh_en),
        .ier    (ier_q)
    );

    // pin_rise[0]: rts, pin_rise[1]: cts
    uart_irq_edge #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({cts_pin, rts_pin}),
        .rise  (pin_rise)
    );

    always_comb begin
        src_en[SRC_LINE]  = ier_q[EN_LS];
        src_en[SRC_RXRDY] = ier_q[EN_RX];
        src_en[SRC_RXTO]  = ier_q[EN_RX];
        src_en[SRC_TXE]   = ier_q[EN_TX];
        src_en[SRC_MODEM] = ier_q[EN_MS];
        src_en[SRC_XOFF]  = ier_q[EN_XOFF];
        src_en[SRC_FLOW]  = ier_q[EN_RTS] | ier_q[EN_CTS];

        src_set[SRC_LINE]  = line_err   & ier_q[EN_LS];
        src_set[SRC_RXRDY] = rx_ready   & ier_q[EN_RX];
        src_set[SRC_RXTO]  = rx_timeout & ier_q[EN_RX];
        src_set[SRC_TXE]   = tx_empty   & ier_q[EN_TX];
        src_set[SRC_MODEM] = modem_chg  & ier_q[EN_MS];
        src_set[SRC_XOFF]  = xoff_det   & ier_q[EN_XOFF];
        src_set[SRC_FLOW]  = (pin_rise[0] & ier_q[EN_RTS]) |
                             (pin_rise[1] & ier_q[EN_CTS]);
    end

    uart_irq_prio #(.N(NUM_SRC)) u_prio (
        .req   (pend & src_en),
        .grant (grant),
        .sel   (win),
        .valid (any)
    );

    always_comb begin
        src_clr = isr_rd ? grant : '0;
    end

    uart_irq_latch #(.N(NUM_SRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set),
        .clr_i  (src_clr),
        .pend_o (pend)
    );

    always_comb begin
        unique case (win)
            SRC_LINE:  code = 6'b000110;
            SRC_RXRDY: code = 6'b000100;
            SRC_RXTO:  code = {2'b00, fifo_en, 3'b100};
            SRC_TXE:   code = 6'b000010;
            SRC_MODEM: code = 6'b000000;
            SRC_XOFF:  code = 6'b010000;
            SRC_FLOW:  code = 6'b100000;
            SRC_NONE:  code = 6'b000001;
        endcase
        isr_data = {fifo_en, fifo_en, code};
        irq      = any;
    end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_wr,
    input logic       enh_en,
    input logic       fifo_en,
    input logic       line_err,
    input logic       isr_rd,
    input logic [7:0] ier_q,
    input logic [7:0] isr_data,
    input logic       irq
);

    // R3
    bit0_vs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq != isr_data[0]);

    // R6
    fifo_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |-> isr_data[7:6] == 2'b11);

    // R5
    no_timeout_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !isr_data[3]);

    // R7
    upper_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && !enh_en) |=> ier_q[7:4] == $past(ier_q[7:4]));

    // R4
    line_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && isr_data[5:0] == 6'b000110 && !line_err) |=> isr_data[5:0] != 6'b000110);

    // R9
    line_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && ier_q[2] && !ier_wr) |=> irq);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ier_wr   (ier_wr),
    .enh_en   (enh_en),
    .fifo_en  (fifo_en),
    .line_err (line_err),
    .isr_rd   (isr_rd),
    .ier_q    (ier_q),
    .isr_data (isr_data),
    .irq      (irq)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       ier_wr = 0;
    logic [7:0] ier_wdata = 0;
    logic       enh_en = 0, fifo_en = 0;
    logic       line_err = 0, rx_ready = 0, rx_timeout = 0, tx_empty = 0;
    logic       modem_chg = 0, xoff_det = 0, cts_pin = 0, rts_pin = 0;
    logic       isr_rd = 0;
    logic [7:0] isr_data;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_ident dut (.*);

    // ---------------- behavioural reference model ----------------
    int       m_pend [7];
    bit [7:0] m_ier;
    bit       m_prev_c, m_prev_r;

    function automatic bit m_en(int s);
        case (s)
            0: return m_ier[2];
            1: return m_ier[0];
            2: return m_ier[0];
            3: return m_ier[1];
            4: return m_ier[3];
            5: return m_ier[5];
            default: return m_ier[6] || m_ier[7];
        endcase
    endfunction

    function automatic int m_top();
        for (int s = 0; s < 7; s++)
            if (m_pend[s] != 0 && m_en(s)) return s;
        return -1;
    endfunction

    function automatic bit [7:0] m_isr();
        bit [5:0] c;
        case (m_top())
            0: c = 6'h06;
            1: c = 6'h04;
            2: c = fifo_en ? 6'h0C : 6'h04;
            3: c = 6'h02;
            4: c = 6'h00;
            5: c = 6'h10;
            6: c = 6'h20;
            default: c = 6'h01;
        endcase
        return {fifo_en, fifo_en, c};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < 7; s++) m_pend[s] = 0;
            m_ier = 0; m_prev_c = 0; m_prev_r = 0;
        end else begin
            int sets [7];
            int t;
            t = m_top();
            sets[0] = line_err   && m_ier[2];
            sets[1] = rx_ready   && m_ier[0];
            sets[2] = rx_timeout && m_ier[0];
            sets[3] = tx_empty   && m_ier[1];
            sets[4] = modem_chg  && m_ier[3];
            sets[5] = xoff_det   && m_ier[5];
            sets[6] = (rts_pin && !m_prev_r && m_ier[6]) || (cts_pin && !m_prev_c && m_ier[7]);
            if (isr_rd && t >= 0) m_pend[t] = 0;
            for (int s = 0; s < 7; s++) if (sets[s] != 0) m_pend[s] = 1;
            if (ier_wr) begin
                m_ier[3:0] = ier_wdata[3:0];
                if (enh_en) m_ier[7:4] = ier_wdata[7:4];
            end
            m_prev_c = cts_pin; m_prev_r = rts_pin;
        end
    end

    // per-cycle comparison, away from both edges
    always @(posedge clk) begin
        #7;
        if (rst_n && !done) begin
            checks++;
            if (isr_data !== m_isr() || irq !== (m_top() >= 0)) begin
                errors++;
                $display("FAIL R2/R3/R11 model: isr=%h irq=%b expected isr=%h irq=%b",
                         isr_data, irq, m_isr(), m_top() >= 0);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic step();
        @(posedge clk); #3;
    endtask

    task automatic chk(string tag, bit [7:0] exp);
        checks++;
        if (isr_data !== exp || irq !== !exp[0]) begin
            errors++;
            $display("FAIL %s: isr=%h irq=%b expected isr=%h irq=%b", tag, isr_data, irq, exp, !exp[0]);
        end
    endtask

    task automatic wr_ier(bit [7:0] v, bit enh);
        ier_wr = 1; ier_wdata = v; enh_en = enh;
        step();
        ier_wr = 0; enh_en = 0;
    endtask

    task automatic rd();
        isr_rd = 1; step(); isr_rd = 0;
    endtask

    initial begin
        #1;
        chk("R1 reset", 8'h01);
        #50 rst_n = 1;
        step();
        chk("R1 after reset", 8'h01);

        // R7: upper half locked without enh_en
        wr_ier(8'hFF, 0);
        cts_pin = 1; rts_pin = 1; step();
        chk("R7 locked upper bits, no flow interrupt", 8'h01);
        cts_pin = 0; rts_pin = 0; step();

        // R9: latched after pulse drops
        line_err = 1; step(); line_err = 0; step();
        chk("R9 line error latched", 8'h06);

        // R4 / R2: read-out order
        tx_empty = 1; modem_chg = 1; step(); tx_empty = 0; modem_chg = 0;
        chk("R2 line error still wins", 8'h06);
        rd(); chk("R4 next is tx empty", 8'h02);
        rd(); chk("R2 modem code", 8'h00);
        rd(); chk("R4 all cleared", 8'h01);

        // R5 / R6
        fifo_en = 1; rx_timeout = 1; step(); rx_timeout = 0;
        chk("R5 R6 timeout in fifo mode", 8'hCC);
        fifo_en = 0; #1;
        chk("R5 timeout outside fifo mode", 8'h04);
        fifo_en = 1; #1;
        rd(); chk("R6 fifo flags with nothing pending", 8'hC1);
        fifo_en = 0;

        // R12: level still present across read
        rx_ready = 1; step();
        rd(); chk("R12 level source re-asserts", 8'h04);
        rx_ready = 0; rd(); chk("R12 cleared after drop", 8'h01);

        // R10: mask without drop
        line_err = 1; step(); line_err = 0;
        wr_ier(8'h0B, 0); chk("R10 masked", 8'h01);
        wr_ier(8'h0F, 0); chk("R10 unmasked again", 8'h06);
        rd();

        // R8: edges with enhanced enables
        wr_ier(8'hEF, 1);
        cts_pin = 1; step(); chk("R8 cts rise", 8'h20);
        rd(); chk("R8 cts level gives nothing", 8'h01);
        cts_pin = 0; step(); chk("R8 cts fall gives nothing", 8'h01);
        rts_pin = 1; step(); chk("R8 rts rise", 8'h20);
        rts_pin = 0; rd();
        xoff_det = 1; step(); xoff_det = 0;
        chk("R2 flow-off code", 8'h10);
        rd();

        // R7: with enh_en clear, bit 6 of enable is kept
        wr_ier(8'h0F, 0);
        rts_pin = 1; step(); rts_pin = 0;
        chk("R7 upper bits kept", 8'h20);
        rd();

        // R2 / R4: everything at once
        line_err = 1; rx_ready = 1; tx_empty = 1; modem_chg = 1; xoff_det = 1;
        step();
        line_err = 0; rx_ready = 0; tx_empty = 0; modem_chg = 0; xoff_det = 0;
        wr_ier(8'hEF, 1);
        chk("R2 rank 1", 8'h06); rd();
        chk("R2 rank 2", 8'h04); rd();
        chk("R2 rank 4", 8'h02); rd();
        chk("R2 rank 5", 8'h00); rd();
        chk("R2 rank 6", 8'h10); rd();
        chk("R11 idle", 8'h01);

        step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: timeout expected completion");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule